// File: doc/BRIEF.md
# Packed SIMD Media ALU

This block is a packed-integer arithmetic unit for 32-bit words. Each operation treats its operands either as two 16-bit lanes or as four 8-bit lanes and computes every lane on its own, with no carry or borrow crossing a lane boundary. It covers several groups of operations:

- lane add and subtract, in wrapping and saturating forms;
- a per-byte select driven by stored comparison flags;
- halfword packing with a shift;
- byte and halfword extraction with zero or sign extension, including a two-byte form;
- an unsigned byte sum of absolute differences with accumulate;
- a saturating doubling of a signed 32-bit value.

A caller presents an opcode, two operands, an accumulator value and a shift amount together with a valid strobe. The result appears on a register one cycle later. A sticky flag records that some clamp has occurred since it was last cleared.

Opcode decode is held apart from the datapath. The lane adders come from one parametrised lane unit, built at 8-bit and 16-bit width.

Top module: `simd_media_alu`

## Requirements
- R1: Wrapping lane add/subtract uses opcodes 0 to 7. Bit 0 selects subtract, bit 1 selects unsigned, and bit 2 selects 8-bit lanes rather than 16-bit lanes (16-bit lanes are bits 15:0 and 31:16; byte lane i is bits 8i+7:8i). Each lane result is the low lane bits of A op B, and no carry passes between lanes.
- R2: Wrapping opcodes 0 to 7 update a 4-bit flag register with one bit per byte position. A 16-bit op writes its lane's flag into both byte bits. Each flag is set as follows: for signed ops, when the exact result is at least 0; for an unsigned add, when the lane carries out; for an unsigned subtract, when A is at least B. All other opcodes leave the flags unchanged. The flags reset to 0.
- R3: Opcode 16 (select) returns byte i of A when flag i is 1 and byte i of B when it is 0.
- R4: Opcodes 8 to 15 use the same bit meanings as R1 but saturate. Signed lanes clamp to [-2^(n-1), 2^(n-1)-1].
- R5: In the saturating unsigned ops, lanes clamp to [0, 2^n-1].
- R6: The output satSticky goes to 1 one cycle after any accepted operation that clamps, in a lane or in doubling. It holds until satClear is 1 at a clock edge, which forces it to 0 and takes priority over a clamp in the same cycle. Its reset value is 0.
- R7: Opcode 17 returns {(B << shamt)[31:16], A[15:0]}. Opcode 18 returns {A[31:16], (B arithmetically shifted right by shamt)[15:0]}.
- R8: Opcodes 19 to 22 first rotate B right by 8*shamt[1:0] bits. They then return the rotated value's low field, extended to 32 bits. Opcode 19 sign-extends a byte, 20 zero-extends a byte, 21 sign-extends a halfword and 22 zero-extends a halfword.
- R9: Opcodes 23 (sign) and 24 (zero) start from the same rotated B. Rotated bits 7:0 are extended into result bits 15:0, and rotated bits 23:16 are extended into result bits 31:16.
- R10: Opcode 25 returns accIn plus the sum of |A byte i - B byte i| over the four unsigned byte lanes, modulo 2^32.
- R11: Opcode 26 returns A shifted left by one. If A[31] differs from A[30], the result is instead 0x80000000 when A is negative and 0x7FFFFFFF when A is positive, and a clamp is recorded.
- R12: outValid is 1 exactly in the cycle after a cycle with inValid high. result takes the new value at that same edge and holds it while inValid is low. result and outValid reset to 0.
- R13: Opcodes 27 to 31 return 0. They change neither the flags nor satSticky.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Accepts the operation on the inputs this cycle |
| opcode | input | 5 | Operation select |
| opA | input | 32 | Operand A |
| opB | input | 32 | Operand B |
| accIn | input | 32 | Accumulator for the sum of absolute differences |
| shamt | input | 5 | Pack shift amount; bits 1:0 are the extraction byte rotation |
| satClear | input | 1 | Clears the sticky saturation flag |
| outValid | output | 1 | Registered valid, one cycle after inValid |
| result | output | 32 | Registered operation result |
| satSticky | output | 1 | Sticky saturation flag |

## Verification
Every result, the registered valid and the sticky flag are due at the first rising edge after the strobe. The lane flags take effect for a select accepted in any later cycle. The bench drives each operation on a falling edge and checks result, outValid and satSticky on the following falling edge, half a cycle after the capturing edge. It reads the flag register back only through a select issued afterwards. Back-to-back strobes are checked one cycle apart, and idle cycles confirm that result holds and outValid is low.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int WORD_W    = 32;
  localparam int BYTE_W    = 8;
  localparam int HALF_W    = 16;
  localparam int NUM_BYTES = WORD_W / BYTE_W;
  localparam int NUM_HALVES = WORD_W / HALF_W;
  localparam int BYTES_PER_HALF = HALF_W / BYTE_W;
  localparam int OP_W      = 5;
  localparam int SHAMT_W   = $clog2(WORD_W);

  typedef enum logic [OP_W-1:0] {
    OP_SEL_BYTES = 5'd16,
    OP_PACK_LOW  = 5'd17,
    OP_PACK_HIGH = 5'd18,
    OP_XT_SBYTE  = 5'd19,
    OP_XT_UBYTE  = 5'd20,
    OP_XT_SHALF  = 5'd21,
    OP_XT_UHALF  = 5'd22,
    OP_XT_SPAIR  = 5'd23,
    OP_XT_UPAIR  = 5'd24,
    OP_SAD_ACC   = 5'd25,
    OP_DBL_SAT   = 5'd26
  } misc_op_e;

  typedef struct packed {
    logic arithOp;
    logic laneByte;
    logic isSub;
    logic isSigned;
    logic isSat;
    logic wrGe;
    logic selOp;
    logic packLo;
    logic packHi;
    logic extOp;
    logic extHalf;
    logic extSigned;
    logic extDual;
    logic sadOp;
    logic dblOp;
  } ctrl_strobes_t;
endpackage

// File: rtl/simd_lane_arith.sv
module simd_lane_arith #(
  parameter int LW = 8
) (
  input  logic [LW-1:0] laneA,
  input  logic [LW-1:0] laneB,
  input  logic          isSub,
  input  logic          isSigned,
  input  logic          isSat,
  output logic [LW-1:0] laneRes,
  output logic          laneGe,
  output logic          laneSat
);
  localparam int EW = LW + 2;
  localparam logic signed [EW-1:0] SMAX = EW'((1 << (LW - 1)) - 1);
  localparam logic signed [EW-1:0] SMIN = EW'(-(1 << (LW - 1)));
  localparam logic signed [EW-1:0] UMAX = EW'((1 << LW) - 1);

  logic signed [EW-1:0] extA, extB, exact;
  logic overHi, underLo;

  always_comb begin
    extA  = isSigned ? {{2{laneA[LW-1]}}, laneA} : {2'b00, laneA};
    extB  = isSigned ? {{2{laneB[LW-1]}}, laneB} : {2'b00, laneB};
    exact = isSub ? (extA - extB) : (extA + extB);
    if (isSigned) begin
      overHi  = exact > SMAX;
      underLo = exact < SMIN;
      laneGe  = !exact[EW-1];
    end else begin
      overHi  = exact > UMAX;
      underLo = exact[EW-1];
      laneGe  = isSub ? !exact[EW-1] : exact[LW];
    end
    laneSat = isSat && (overHi || underLo);
    if (isSat && overHi)
      laneRes = isSigned ? SMAX[LW-1:0] : UMAX[LW-1:0];
    else if (isSat && underLo)
      laneRes = isSigned ? SMIN[LW-1:0] : '0;
    else
      laneRes = exact[LW-1:0];
  end
endmodule

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [OP_W-1:0] opcode,
  output ctrl_strobes_t   strobes,
  output logic            outValid
);
  always_comb begin
    strobes = '0;
    if (!opcode[OP_W-1]) begin
      strobes.arithOp  = 1'b1;
      strobes.isSub    = opcode[0];
      strobes.isSigned = !opcode[1];
      strobes.laneByte = opcode[2];
      strobes.isSat    = opcode[3];
      strobes.wrGe     = !opcode[3];
    end else begin
      case (opcode)
        OP_SEL_BYTES: strobes.selOp  = 1'b1;
        OP_PACK_LOW:  strobes.packLo = 1'b1;
        OP_PACK_HIGH: strobes.packHi = 1'b1;
        OP_XT_SBYTE: begin strobes.extOp = 1'b1; strobes.extSigned = 1'b1; end
        OP_XT_UBYTE: strobes.extOp = 1'b1;
        OP_XT_SHALF: begin strobes.extOp = 1'b1; strobes.extHalf = 1'b1; strobes.extSigned = 1'b1; end
        OP_XT_UHALF: begin strobes.extOp = 1'b1; strobes.extHalf = 1'b1; end
        OP_XT_SPAIR: begin strobes.extOp = 1'b1; strobes.extDual = 1'b1; strobes.extSigned = 1'b1; end
        OP_XT_UPAIR: begin strobes.extOp = 1'b1; strobes.extDual = 1'b1; end
        OP_SAD_ACC:  strobes.sadOp = 1'b1;
        OP_DBL_SAT:  strobes.dblOp = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  assert_valid_latency_R12: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  ctrl_strobes_t      strobes,
  input  logic [WORD_W-1:0]  opA,
  input  logic [WORD_W-1:0]  opB,
  input  logic [WORD_W-1:0]  accIn,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic               satClear,
  output logic [WORD_W-1:0]  result,
  output logic               satSticky
);
  logic [WORD_W-1:0]    byteRes, halfRes;
  logic [NUM_BYTES-1:0] byteGe, byteSat, halfGeWide, geFlags, geNext;
  logic [NUM_HALVES-1:0] halfGe, halfSat;

  for (genvar gb = 0; gb < NUM_BYTES; gb++) begin : g_byte
    simd_lane_arith #(.LW(BYTE_W)) u_lane (
      .laneA(opA[gb*BYTE_W +: BYTE_W]), .laneB(opB[gb*BYTE_W +: BYTE_W]),
      .isSub(strobes.isSub), .isSigned(strobes.isSigned), .isSat(strobes.isSat),
      .laneRes(byteRes[gb*BYTE_W +: BYTE_W]), .laneGe(byteGe[gb]), .laneSat(byteSat[gb]));
    assign halfGeWide[gb] = halfGe[gb / BYTES_PER_HALF];
  end

  for (genvar gh = 0; gh < NUM_HALVES; gh++) begin : g_half
    simd_lane_arith #(.LW(HALF_W)) u_lane (
      .laneA(opA[gh*HALF_W +: HALF_W]), .laneB(opB[gh*HALF_W +: HALF_W]),
      .isSub(strobes.isSub), .isSigned(strobes.isSigned), .isSat(strobes.isSat),
      .laneRes(halfRes[gh*HALF_W +: HALF_W]), .laneGe(halfGe[gh]), .laneSat(halfSat[gh]));
  end

  assign geNext = strobes.laneByte ? byteGe : halfGeWide;

  logic [WORD_W-1:0]   shiftLeft, shiftArith, rotB, selRes, extRes, sadSum, dblRes, nextRes;
  logic [2*WORD_W-1:0] rotWide;
  logic [BYTE_W-1:0]   byteDiff;
  logic                dblOvf, satHit;

  always_comb begin
    shiftLeft  = opB << shamt;
    shiftArith = $signed(opB) >>> shamt;
    rotWide    = {opB, opB} >> (shamt[1:0] * BYTE_W);
    rotB       = rotWide[WORD_W-1:0];

    for (int i = 0; i < NUM_BYTES; i++)
      selRes[i*BYTE_W +: BYTE_W] = geFlags[i] ? opA[i*BYTE_W +: BYTE_W] : opB[i*BYTE_W +: BYTE_W];

    if (strobes.extDual)
      extRes = {{(HALF_W-BYTE_W){strobes.extSigned & rotB[HALF_W+BYTE_W-1]}}, rotB[HALF_W +: BYTE_W],
                {(HALF_W-BYTE_W){strobes.extSigned & rotB[BYTE_W-1]}}, rotB[BYTE_W-1:0]};
    else if (strobes.extHalf)
      extRes = {{(WORD_W-HALF_W){strobes.extSigned & rotB[HALF_W-1]}}, rotB[HALF_W-1:0]};
    else
      extRes = {{(WORD_W-BYTE_W){strobes.extSigned & rotB[BYTE_W-1]}}, rotB[BYTE_W-1:0]};

    sadSum   = accIn;
    byteDiff = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (opA[i*BYTE_W +: BYTE_W] > opB[i*BYTE_W +: BYTE_W])
        byteDiff = opA[i*BYTE_W +: BYTE_W] - opB[i*BYTE_W +: BYTE_W];
      else
        byteDiff = opB[i*BYTE_W +: BYTE_W] - opA[i*BYTE_W +: BYTE_W];
      sadSum = sadSum + WORD_W'(byteDiff);
    end

    dblOvf = opA[WORD_W-1] ^ opA[WORD_W-2];
    if (!dblOvf)             dblRes = {opA[WORD_W-2:0], 1'b0};
    else if (opA[WORD_W-1])  dblRes = {1'b1, {(WORD_W-1){1'b0}}};
    else                     dblRes = {1'b0, {(WORD_W-1){1'b1}}};

    nextRes = '0;
    satHit  = 1'b0;
    if (strobes.arithOp) begin
      nextRes = strobes.laneByte ? byteRes : halfRes;
      satHit  = strobes.laneByte ? |byteSat : |halfSat;
    end else if (strobes.selOp)  nextRes = selRes;
    else if (strobes.packLo)     nextRes = {shiftLeft[WORD_W-1:HALF_W], opA[HALF_W-1:0]};
    else if (strobes.packHi)     nextRes = {opA[WORD_W-1:HALF_W], shiftArith[HALF_W-1:0]};
    else if (strobes.extOp)      nextRes = extRes;
    else if (strobes.sadOp)      nextRes = sadSum;
    else if (strobes.dblOp) begin
      nextRes = dblRes;
      satHit  = dblOvf;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result    <= '0;
      geFlags   <= '0;
      satSticky <= 1'b0;
    end else begin
      if (inValid) result <= nextRes;
      if (inValid && strobes.wrGe) geFlags <= geNext;
      if (satClear) satSticky <= 1'b0;
      else if (inValid && satHit) satSticky <= 1'b1;
    end
  end

  assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));
  assert_sticky_keep_R6: assert property (@(posedge clk) disable iff (!rstN)
    satSticky && !satClear |=> satSticky);
  assert_sticky_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    satClear |=> !satSticky);
  assert_dbl_clamp_R11: assert property (@(posedge clk) disable iff (!rstN)
    inValid && strobes.dblOp && (opA[WORD_W-1] != opA[WORD_W-2]) && !satClear |=> satSticky);
  assert_ge_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && strobes.wrGe) |=> $stable(geFlags));
endmodule

// File: rtl/simd_media_alu.sv
module simd_media_alu
  import simd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [OP_W-1:0]    opcode,
  input  logic [WORD_W-1:0]  opA,
  input  logic [WORD_W-1:0]  opB,
  input  logic [WORD_W-1:0]  accIn,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic               satClear,
  output logic               outValid,
  output logic [WORD_W-1:0]  result,
  output logic               satSticky
);
  ctrl_strobes_t strobes;

  simd_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .strobes(strobes), .outValid(outValid));

  simd_datapath i_datapath (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strobes(strobes),
    .opA(opA), .opB(opB), .accIn(accIn), .shamt(shamt), .satClear(satClear),
    .result(result), .satSticky(satSticky));
endmodule

// File: tb/test_simd_media_alu.sv
module test_simd_media_alu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [4:0]  opcode = '0;
  logic [31:0] opA = '0, opB = '0, accIn = '0;
  logic [4:0]  shamt = '0;
  logic        satClear = 1'b0;
  logic        outValid, satSticky;
  logic [31:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [3:0] tbGe = '0;
  bit tbSat = 0;

  always #10 clk = ~clk;

  simd_media_alu i_simd_media_alu (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .opA(opA), .opB(opB), .accIn(accIn), .shamt(shamt), .satClear(satClear),
    .outValid(outValid), .result(result), .satSticky(satSticky));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [4:0] op, input logic [31:0] a, b, acc,
                                        input logic [4:0] sh, output bit hit);
    logic [31:0] r, rot, tl, ts;
    logic [3:0] g;
    int n, full, av, bv, s, lo, hi;
    bit sgn;
    r = '0; hit = 0; g = tbGe;
    tl = b << sh;
    ts = $signed(b) >>> sh;
    rot = b;
    for (int k = 0; k < int'(sh[1:0]); k++) rot = {rot[7:0], rot[31:8]};
    if (!op[4]) begin
      n = op[2] ? 8 : 16; full = 1 << n; sgn = !op[1];
      lo = sgn ? -(full / 2) : 0;
      hi = sgn ? full / 2 - 1 : full - 1;
      for (int l = 0; l < 32 / n; l++) begin
        av = int'((a >> (l * n)) & 32'(full - 1));
        bv = int'((b >> (l * n)) & 32'(full - 1));
        if (sgn && av >= full / 2) av -= full;
        if (sgn && bv >= full / 2) bv -= full;
        s = op[0] ? av - bv : av + bv;
        if (op[3]) begin
          if (s > hi) begin s = hi; hit = 1; end
          else if (s < lo) begin s = lo; hit = 1; end
        end else begin
          for (int k = 0; k < n / 8; k++)
            g[l * (n / 8) + k] = (sgn || op[0]) ? (s >= 0) : (s >= full);
        end
        r |= (32'(s) & 32'(full - 1)) << (l * n);
      end
      tbGe = g;
    end else begin
      case (op)
        5'd16: for (int i = 0; i < 4; i++) r[i*8 +: 8] = tbGe[i] ? a[i*8 +: 8] : b[i*8 +: 8];
        5'd17: r = {tl[31:16], a[15:0]};
        5'd18: r = {a[31:16], ts[15:0]};
        5'd19: r = {{24{rot[7]}}, rot[7:0]};
        5'd20: r = {24'd0, rot[7:0]};
        5'd21: r = {{16{rot[15]}}, rot[15:0]};
        5'd22: r = {16'd0, rot[15:0]};
        5'd23: r = {{8{rot[23]}}, rot[23:16], {8{rot[7]}}, rot[7:0]};
        5'd24: r = {8'd0, rot[23:16], 8'd0, rot[7:0]};
        5'd25: begin
          r = acc;
          for (int i = 0; i < 4; i++) begin
            av = int'(a[i*8 +: 8]); bv = int'(b[i*8 +: 8]);
            r += 32'(av > bv ? av - bv : bv - av);
          end
        end
        5'd26: begin
          if (a[31] != a[30]) begin hit = 1; r = a[31] ? 32'h8000_0000 : 32'h7FFF_FFFF; end
          else r = a << 1;
        end
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  task automatic runOp(input string tag, input logic [4:0] op, input logic [31:0] a, b,
                       input logic [31:0] acc = 0, input logic [4:0] sh = 0, input bit clr = 0);
    logic [31:0] exp;
    bit hit;
    @(negedge clk);
    opcode = op; opA = a; opB = b; accIn = acc; shamt = sh; satClear = clr; inValid = 1'b1;
    exp = model(op, a, b, acc, sh, hit);
    if (clr) tbSat = 0; else if (hit) tbSat = 1;
    @(negedge clk);
    inValid = 1'b0; satClear = 1'b0;
    check({tag, " result"}, result, exp);
    check({tag, " outValid"}, 32'(outValid), 32'd1);
    check({tag, " sticky"}, 32'(satSticky), 32'(tbSat));
  endtask

  task automatic testReset;
    check("R12 reset result", result, 0);
    check("R12 reset outValid", 32'(outValid), 0);
    check("R6 reset sticky", 32'(satSticky), 0);
  endtask

  task automatic testWrap;
    runOp("R1 uadd16 no cross-lane carry", 5'd2, 32'h0001_FFFF, 32'h0001_0001);
    runOp("R1 uadd8", 5'd6, 32'h80FF_7F01, 32'h8001_7F01);
    runOp("R1 ssub8", 5'd5, 32'h0080_7F10, 32'h0101_FF20);
    runOp("R1 ssub16", 5'd1, 32'h8000_1234, 32'h0001_4321);
    runOp("R1 usub16 borrow", 5'd3, 32'h0000_0005, 32'h0001_0006);
  endtask

  task automatic testGeSelect;
    runOp("R2 uadd8 carries", 5'd6, 32'hFF00_FF00, 32'h0100_0100);
    runOp("R3 select after uadd8", 5'd16, 32'hFFFF_FFFF, 32'h0000_0000);
    runOp("R2 sat op keeps flags", 5'd8, 32'h7FFF_0000, 32'h0001_0000);
    runOp("R3 select after sat op", 5'd16, 32'hAABB_CCDD, 32'h1122_3344);
    runOp("R2 ssub16 sign test", 5'd1, 32'h0005_0003, 32'h0003_0007);
    runOp("R3 select halfword flags", 5'd16, 32'hFFFF_FFFF, 32'h0000_0000);
    runOp("R2 sadd8 mixed signs", 5'd4, 32'h80_7F_05_FE, 32'h01_01_FB_01);
    runOp("R3 select byte flags", 5'd16, 32'h1122_3344, 32'h5566_7788);
    runOp("R2 usub8 a>=b", 5'd7, 32'h0510_2000, 32'h0610_1F01);
    runOp("R13 illegal op", 5'd29, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    runOp("R13 select after illegal", 5'd16, 32'hFFFF_FFFF, 32'h0000_0000);
  endtask

  task automatic testSaturate;
    runOp("R6 clear before sat", 5'd2, 32'h0, 32'h0, 0, 0, 1);
    runOp("R4 qadd16 signed clamp", 5'd8, 32'h7FFF_8000, 32'h0001_8000);
    runOp("R6 sticky persists", 5'd2, 32'h1, 32'h1);
    runOp("R6 clear", 5'd2, 32'h1, 32'h1, 0, 0, 1);
    runOp("R4 qsub8 signed clamp", 5'd13, 32'h80_7F_10_00, 32'h01_FF_20_00);
    runOp("R6 clear wins over clamp", 5'd14, 32'hFFFF_FFFF, 32'h0101_0101, 0, 0, 1);
    runOp("R5 uqadd8 clamp", 5'd14, 32'hFF10_80FE, 32'h0120_8001);
    runOp("R5 uqsub16 clamp", 5'd11, 32'h0001_9000, 32'h0002_1000, 0, 0, 1);
    runOp("R4 in-range no clamp", 5'd9, 32'h0010_0020, 32'h0001_0002, 0, 0, 1);
    runOp("R13 illegal keeps sticky clear", 5'd31, 32'h7FFF_7FFF, 32'h7FFF_7FFF);
  endtask

  task automatic testPack;
    runOp("R7 pack low shift 0", 5'd17, 32'hAAAA_BBBB, 32'hCCCC_DDDD, 0, 0);
    runOp("R7 pack low shift 4", 5'd17, 32'hAAAA_BBBB, 32'h1234_5678, 0, 4);
    runOp("R7 pack high shift 16", 5'd18, 32'hAAAA_BBBB, 32'h8765_4321, 0, 16);
    runOp("R7 pack high shift 31", 5'd18, 32'hAAAA_BBBB, 32'h8000_0000, 0, 31);
  endtask

  task automatic testExtract;
    runOp("R8 sbyte rot0", 5'd19, 32'h0, 32'h1234_5680, 0, 0);
    runOp("R8 ubyte rot1", 5'd20, 32'h0, 32'h1234_F678, 0, 1);
    runOp("R8 shalf rot2", 5'd21, 32'h0, 32'h8234_5678, 0, 2);
    runOp("R8 uhalf rot3", 5'd22, 32'h0, 32'h8934_56A8, 0, 3);
    runOp("R9 spair rot0", 5'd23, 32'h0, 32'h1280_347F, 0, 0);
    runOp("R9 upair rot1", 5'd24, 32'h0, 32'hF1E2_D3C4, 0, 1);
  endtask

  task automatic testSadDbl;
    runOp("R10 sad accumulate", 5'd25, 32'h0010_FF00, 32'h0020_0001, 32'd100);
    runOp("R10 sad wrap", 5'd25, 32'hFF00_FF00, 32'h00FF_00FF, 32'hFFFF_FFFF);
    runOp("R11 dbl no clamp", 5'd26, 32'h1234_5678, 32'h0);
    runOp("R11 dbl negative ok", 5'd26, 32'hC000_0000, 32'h0);
    runOp("R11 dbl positive clamp", 5'd26, 32'h4000_0000, 32'h0);
    runOp("R11 dbl negative clamp", 5'd26, 32'hA000_0000, 32'h0, 0, 0, 1);
    runOp("R6 clear after dbl", 5'd30, 32'h0, 32'h0, 0, 0, 1);
    runOp("R11 dbl clamp sets sticky", 5'd26, 32'hA000_0000, 32'h0);
  endtask

  task automatic testTiming;
    logic [31:0] held;
    bit hit;
    held = result;
    @(negedge clk);
    opcode = 5'd2; opA = 32'h1111_1111; opB = 32'h2222_2222; inValid = 1'b0;
    @(negedge clk);
    check("R12 hold no strobe result", result, held);
    check("R12 idle outValid low", 32'(outValid), 0);
    opcode = 5'd2; opA = 32'h0001_0002; opB = 32'h0003_0004; inValid = 1'b1;
    void'(model(5'd2, 32'h0001_0002, 32'h0003_0004, 0, 0, hit));
    @(negedge clk);
    check("R12 back-to-back first", result, 32'h0004_0006);
    check("R12 back-to-back valid", 32'(outValid), 1);
    opcode = 5'd25; opA = 32'h0000_0009; opB = 32'h0000_0002; accIn = 32'd5;
    @(negedge clk);
    inValid = 1'b0;
    check("R12 back-to-back second", result, 32'd12);
    check("R12 back-to-back valid 2", 32'(outValid), 1);
    @(negedge clk);
    check("R12 valid drops", 32'(outValid), 0);
    check("R12 result held", result, 32'd12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWrap();
    testGeSelect();
    testSaturate();
    testPack();
    testExtract();
    testSadDbl();
    testTiming();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule